// File: doc/BRIEF.md
# Cascadable Serial Control and Status Register

This block is the serial front end of a cascadable LED driver. A host feeds a 36-bit configuration word into it over a slow serial link made of a shift clock, a data line and a LOAD strobe. The serial output of one part feeds the serial input of the next, so a chain of parts behaves like one long shift register. While LOAD is low, every rising shift-clock edge moves the word along by one bit.

Raising LOAD stops shifting. The first falling shift-clock edge after that copies the 36-bit word into the parallel control registers. These registers drive the PWM address, the two 10-bit PWM words, the watchdog disable flag, the PWM clock divisor and the two 4-bit brightness DAC codes. The next rising edge, with LOAD still high, loads a 36-bit status word into the shifter. After LOAD falls, the host reads that word out while it shifts the next configuration word in.

All the logic runs on a fast core clock. The shift clock, LOAD and serial data inputs are synchronised to that clock and their edges are detected in it.

Top module: `ldd_serial_ctrl`

## Requirements
- R1: After reset every control output is 0, which leaves the watchdog enabled (`wdog_dis_o` = 0), and `ser_o` is 0.
- R2: While LOAD is low, each rising shift-clock edge shifts `ser_i` into bit 1 and moves every bit up by one. `ser_o` always shows bit 36, so a bit appears on `ser_o` 36 rising edges after it entered.
- R3: Control field map, with the lower-numbered bit as the LSB of each field:
  - address in bits 1–3
  - bank-A PWM word in bits 4–13
  - bank-B PWM word in bits 14–23
  - watchdog disable in bit 24 (1 = disabled)
  - divisor in bits 25–28
  - bank-A DAC code in bits 29–32
  - bank-B DAC code in bits 33–36

  The first bit shifted in ends up in bit 36.
- R4: While LOAD is high, rising edges that come before the commit leave the shift register unchanged.
- R5: The first falling shift-clock edge after LOAD rises copies the shift register into the control outputs. The control outputs change at no other time.
- R6: The next rising edge after the commit, with LOAD still high, loads the status word. After LOAD returns low, the status word leaves on `ser_o` bit 36 first, one bit per rising edge.
- R7: Status bit map:
  - bits 1–8: bank-A output good flags (0 = open circuit)
  - bits 9–16: bank-B output good flags (0 = open circuit)
  - bit 17: watchdog timeout
  - bit 18: overtemperature
  - bits 19–21: mask revision, LSB first
- R8: Status bits 22–36 are a fixed filler. Bit k is 1 when 36−k is odd, so bit 36 is 0 and `ser_o` reads 0 right after the capture.
- R9: Each LOAD-high interval performs at most one commit and one capture. Further shift-clock edges change neither the control outputs nor the captured status.
- R10: Falling shift-clock edges while LOAD is low do not change the control outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk_i | input | 1 | Serial shift clock, asynchronous to `clk` |
| load_i | input | 1 | LOAD strobe |
| ser_i | input | 1 | Serial data in |
| ser_o | output | 1 | Serial data out (bit 36) |
| out_ok_a_i | input | 8 | Bank-A output good flags (0 = open) |
| out_ok_b_i | input | 8 | Bank-B output good flags (0 = open) |
| wdog_to_i | input | 1 | Watchdog timeout flag |
| hot_i | input | 1 | Overtemperature flag |
| mask_rev_i | input | 3 | Mask revision code |
| pwm_addr_o | output | 3 | PWM address |
| pwm_a_o | output | 10 | Bank-A PWM word |
| pwm_b_o | output | 10 | Bank-B PWM word |
| wdog_dis_o | output | 1 | Watchdog disable |
| divisor_o | output | 4 | PWM clock divisor code |
| dac_a_o | output | 4 | Bank-A DAC code |
| dac_b_o | output | 4 | Bank-B DAC code |

## Verification
A change on a serial input is seen on the third rising core-clock edge after it happens. Two of those edges are spent in the synchroniser. On the third, the detected shift-clock edge updates the shift register, and with it `ser_o`, or the control registers. The bench holds each shift-clock level for six core cycles and samples `ser_o` or the control outputs at the end of that half period. This leaves three cycles of margin after the result is due and comes before the next edge can change it. Each commit is checked after its falling edge and each serial bit after its rising edge, including the ignored rise under LOAD and the extra edges of a held LOAD.

// File: rtl/ldd_chain_pkg.sv
// Package: shared widths, control word type and the status word builder
// for the cascadable serial control/status register.
// Assumes word bit k (numbered from 1) lives at vector index k-1.
package ldd_chain_pkg;
    localparam int ADDR_W  = 3;
    localparam int PWM_W   = 10;
    localparam int DIV_W   = 4;
    localparam int DAC_W   = 4;
    localparam int BANK_N  = 8;
    localparam int REV_W   = 3;
    localparam int WORD_W  = ADDR_W + 2*PWM_W + 1 + DIV_W + 2*DAC_W;
    localparam int STAT_USED = 2*BANK_N + 2 + REV_W;

    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_WAIT_FALL = 2'd1,
        PH_WAIT_RISE = 2'd2,
        PH_DONE      = 2'd3
    } phase_t;

    // First member is the MSB, so a cast of the shift word gives the field map.
    typedef struct packed {
        logic [DAC_W-1:0]  dac_b;
        logic [DAC_W-1:0]  dac_a;
        logic [DIV_W-1:0]  div;
        logic              wdog_dis;
        logic [PWM_W-1:0]  pwm_b;
        logic [PWM_W-1:0]  pwm_a;
        logic [ADDR_W-1:0] addr;
    } ctrl_t;

    // Assemble the readback word: flags low, alternating filler high.
    function automatic logic [WORD_W-1:0] build_status(
        input logic [BANK_N-1:0] ok_a,
        input logic [BANK_N-1:0] ok_b,
        input logic              wdog_to,
        input logic              hot,
        input logic [REV_W-1:0]  rev
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[STAT_USED-1:0] = {rev, hot, wdog_to, ok_b, ok_a};
        for (int j = STAT_USED; j < WORD_W; j++) begin
            w[j] = ((WORD_W - 1 - j) % 2) == 1;
        end
        return w;
    endfunction
endpackage

// File: rtl/ldd_sync.sv
// Module: multi-stage synchroniser for slow asynchronous serial pins.
// Assumes each input holds its level for several core clocks.
module ldd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Each stage retimes the previous stage by one core clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else if (g == 0) stg[g] <= async_i;
                else stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/ldd_shift_core.sv
// Module: 36-bit shifter with LOAD phase tracking. Shifts on rising
// shift-clock edges while LOAD is low. Under LOAD it issues one commit
// on the first falling edge and one status capture on the next rising edge.
// Assumes synchronised inputs whose edges are at least one clock apart.
module ldd_shift_core
    import ldd_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              load_s,
    input  logic              ser_s,
    input  logic [WORD_W-1:0] status_i,
    output logic [WORD_W-1:0] sr_o,
    output logic              ser_o,
    output logic              commit_o,
    output logic              capture_o
);
    logic              sclk_q;
    logic              rise_ev, fall_ev, shift_en;
    logic [WORD_W-1:0] sr_q;
    phase_t            phase_q;
    logic [1:0]        commit_cnt_q;

    // Previous shift-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else sclk_q <= sclk_s;
    end

    assign rise_ev = sclk_s & ~sclk_q;
    assign fall_ev = ~sclk_s & sclk_q;

    // Decode the actions allowed in the current phase.
    always_comb begin
        shift_en  = !load_s && rise_ev;
        commit_o  = load_s && fall_ev &&
                    (phase_q == PH_IDLE || phase_q == PH_WAIT_FALL);
        capture_o = load_s && rise_ev && (phase_q == PH_WAIT_RISE);
    end

    // Phase tracker for one LOAD-high interval.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else if (!load_s) phase_q <= PH_IDLE;
        else if (commit_o) phase_q <= PH_WAIT_RISE;
        else if (capture_o) phase_q <= PH_DONE;
        else if (phase_q == PH_IDLE) phase_q <= PH_WAIT_FALL;
    end

    // Shift register: serial shift or status capture.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[WORD_W-2:0], ser_s};
        else if (capture_o) sr_q <= status_i;
    end

    // Commits seen in the current LOAD-high interval (checking aid).
    always_ff @(posedge clk) begin
        if (!rst_n || !load_s) commit_cnt_q <= 2'd0;
        else if (commit_o && commit_cnt_q != 2'd3) commit_cnt_q <= commit_cnt_q + 2'd1;
    end

    assign sr_o  = sr_q;
    assign ser_o = sr_q[WORD_W-1];

    // R4: under LOAD, rising edges before the capture do not move the word.
    assert_hold_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_s && rise_ev && phase_q != PH_WAIT_RISE) |=> $stable(sr_q));

    // R9: never more than one commit per LOAD-high interval.
    assert_single_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_cnt_q <= 2'd1);
endmodule

// File: rtl/ldd_ctrl_regs.sv
// Module: parallel control registers, loaded only on a commit pulse.
// Assumes the word presented with the commit is the final shifted word.
module ldd_ctrl_regs
    import ldd_chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [WORD_W-1:0] word_i,
    output ctrl_t             ctrl_o
);
    ctrl_t word_q;

    // Hold the committed word; reset gives all-off with the watchdog enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else if (commit_i) word_q <= ctrl_t'(word_i);
    end

    assign ctrl_o = word_q;

    // R5: control outputs change only on a commit.
    assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(word_q));
endmodule

// File: rtl/ldd_serial_ctrl.sv
// Module: top of the cascadable serial control/status register.
// Synchronises the serial pins, runs the shifter and phase tracker,
// and fans the committed word out as control fields.
// Assumes the serial pins are slow against clk (several clocks per level).
module ldd_serial_ctrl
    import ldd_chain_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_clk_i,
    input  logic              load_i,
    input  logic              ser_i,
    output logic              ser_o,
    input  logic [BANK_N-1:0] out_ok_a_i,
    input  logic [BANK_N-1:0] out_ok_b_i,
    input  logic              wdog_to_i,
    input  logic              hot_i,
    input  logic [REV_W-1:0]  mask_rev_i,
    output logic [ADDR_W-1:0] pwm_addr_o,
    output logic [PWM_W-1:0]  pwm_a_o,
    output logic [PWM_W-1:0]  pwm_b_o,
    output logic              wdog_dis_o,
    output logic [DIV_W-1:0]  divisor_o,
    output logic [DAC_W-1:0]  dac_a_o,
    output logic [DAC_W-1:0]  dac_b_o
);
    logic [2:0]        pins_s;
    logic [WORD_W-1:0] status_w, sr_w;
    logic              commit_w, capture_w;
    ctrl_t             ctrl_w;

    ldd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({shift_clk_i, load_i, ser_i}),
        .sync_o  (pins_s)
    );

    // Status word seen by the shifter at capture time.
    always_comb begin
        status_w = build_status(out_ok_a_i, out_ok_b_i, wdog_to_i, hot_i, mask_rev_i);
    end

    ldd_shift_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[2]),
        .load_s    (pins_s[1]),
        .ser_s     (pins_s[0]),
        .status_i  (status_w),
        .sr_o      (sr_w),
        .ser_o     (ser_o),
        .commit_o  (commit_w),
        .capture_o (capture_w)
    );

    ldd_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_w),
        .word_i   (sr_w),
        .ctrl_o   (ctrl_w)
    );

    assign pwm_addr_o = ctrl_w.addr;
    assign pwm_a_o    = ctrl_w.pwm_a;
    assign pwm_b_o    = ctrl_w.pwm_b;
    assign wdog_dis_o = ctrl_w.wdog_dis;
    assign divisor_o  = ctrl_w.div;
    assign dac_a_o    = ctrl_w.dac_a;
    assign dac_b_o    = ctrl_w.dac_b;

    // R3: after a commit the outputs carry the shifter fields.
    assert_commit_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_w |=> (pwm_addr_o == $past(sr_w[2:0]) && pwm_a_o == $past(sr_w[12:3])
                      && dac_b_o == $past(sr_w[35:32])));

    // R8: the first bit out after a capture is the filler zero.
    assert_first_filler_R8: assert property (@(posedge clk) disable iff (!rst_n)
        capture_w |=> (ser_o == 1'b0));
endmodule

// File: tb/ldd_serial_ctrl_bench.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops and compares.
module ldd_serial_ctrl_bench;
    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_clk_i = 1'b0, load_i = 1'b0, ser_i = 1'b0;
    logic ser_o;
    logic [7:0] ok_a = 8'h00, ok_b = 8'h00;
    logic wd_to = 1'b0, hot = 1'b0;
    logic [2:0] rev = 3'b000;
    logic [2:0] addr_o;
    logic [9:0] pwm_a_o, pwm_b_o;
    logic wdog_dis_o;
    logic [3:0] div_o, dac_a_o, dac_b_o;

    int checks = 0, failures = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        bit          is_ctrl;
        logic [35:0] exp;
    } item_t;
    item_t sbq[$];
    event chk_ev;

    always #4 clk = ~clk;

    ldd_serial_ctrl u_ldd_serial_ctrl (
        .clk(clk), .rst_n(rst_n), .shift_clk_i(shift_clk_i), .load_i(load_i),
        .ser_i(ser_i), .ser_o(ser_o), .out_ok_a_i(ok_a), .out_ok_b_i(ok_b),
        .wdog_to_i(wd_to), .hot_i(hot), .mask_rev_i(rev),
        .pwm_addr_o(addr_o), .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o),
        .wdog_dis_o(wdog_dis_o), .divisor_o(div_o), .dac_a_o(dac_a_o), .dac_b_o(dac_b_o)
    );

    // Monitor: compares each queued item against the port it names.
    initial begin
        forever begin
            @(chk_ev);
            while (sbq.size() > 0) begin
                item_t it;
                logic [35:0] act;
                it = sbq.pop_front();
                act = it.is_ctrl ? {dac_b_o, dac_a_o, div_o, wdog_dis_o, pwm_b_o, pwm_a_o, addr_o}
                                 : {35'd0, ser_o};
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input string tag, input bit is_ctrl, input logic [35:0] exp);
        item_t it;
        it.tag = tag; it.is_ctrl = is_ctrl; it.exp = exp;
        sbq.push_back(it);
        -> chk_ev;
    endtask

    // Expected status word built bit by bit from the numbering in the requirements.
    function automatic logic [35:0] exp_status(input logic [7:0] a, input logic [7:0] b,
                                               input logic w, input logic h, input logic [2:0] r);
        logic [35:0] s;
        for (int k = 1; k <= 36; k++) begin
            if (k <= 8) s[k-1] = a[k-1];
            else if (k <= 16) s[k-1] = b[k-9];
            else if (k == 17) s[k-1] = w;
            else if (k == 18) s[k-1] = h;
            else if (k <= 21) s[k-1] = r[k-19];
            else s[k-1] = ((36 - k) % 2) == 1;
        end
        return s;
    endfunction

    // Shift a word in MSB first and check each bit leaving the old word.
    task automatic shift_chk(input logic [35:0] w, input logic [35:0] prev, input string tag);
        for (int i = 35; i >= 0; i--) begin
            int k;
            k = 36 - i;
            ser_i = w[i];
            shift_clk_i = 1'b1;
            tick(HP);
            expect_item(tag, 1'b0, {35'd0, (k < 36) ? prev[35-k] : w[35]});
            shift_clk_i = 1'b0;
            tick(HP);
        end
    endtask

    // LOAD sequence: ignored rise, commit fall, capture rise, optional extra edges.
    task automatic load_seq(input logic [35:0] w, input bit extra);
        load_i = 1'b1;
        tick(HP);
        ser_i = ~w[34];
        shift_clk_i = 1'b1;
        tick(HP);
        expect_item("R4 rise under LOAD", 1'b0, {35'd0, w[35]});
        shift_clk_i = 1'b0;
        tick(HP);
        expect_item("R5 R3 commit", 1'b1, w);
        shift_clk_i = 1'b1;
        tick(HP);
        expect_item("R6 R8 capture first bit", 1'b0, 36'd0);
        shift_clk_i = 1'b0;
        tick(HP);
        if (extra) begin
            ok_a = 8'h00; ok_b = 8'hFF; wd_to = 1'b0; hot = 1'b1; rev = 3'b111;
            for (int p = 0; p < 2; p++) begin
                shift_clk_i = 1'b1; tick(HP);
                shift_clk_i = 1'b0; tick(HP);
            end
            expect_item("R9 no second commit", 1'b1, w);
            expect_item("R9 no recapture", 1'b0, 36'd0);
        end
        load_i = 1'b0;
        tick(HP);
    endtask

    initial begin
        logic [35:0] w1, w2, w3, s1, s2;
        w1 = {4'h9, 4'h6, 4'hB, 1'b1, 10'h0F3, 10'h2A7, 3'd5};
        w2 = 36'h6_5C1E_08D2;
        w3 = 36'hA_F00F_1234;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        expect_item("R1 reset ctrl", 1'b1, 36'd0);
        expect_item("R1 reset ser_o", 1'b0, 36'd0);

        shift_chk(w1, 36'd0, "R2 shift");
        expect_item("R10 no commit while shifting", 1'b1, 36'd0);

        ok_a = 8'hA5; ok_b = 8'h3C; wd_to = 1'b1; hot = 1'b0; rev = 3'b101;
        s1 = exp_status(8'hA5, 8'h3C, 1'b1, 1'b0, 3'b101);
        load_seq(w1, 1'b1);
        shift_chk(w2, s1, "R6 R7 readback");
        expect_item("R10 ctrl held", 1'b1, w1);

        ok_a = 8'hFF; ok_b = 8'h81; wd_to = 1'b0; hot = 1'b1; rev = 3'b010;
        s2 = exp_status(8'hFF, 8'h81, 1'b0, 1'b1, 3'b010);
        load_seq(w2, 1'b0);
        shift_chk(w3, s2, "R7 R8 readback");
        load_seq(w3, 1'b0);
        shift_chk(36'h0, exp_status(8'hFF, 8'h81, 1'b0, 1'b1, 3'b010), "R2 R6 readback");

        tick(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule